// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the sync, data-enable and coordinate timing for a single video stream from the pixel clock. Every frame dimension is a run-time input: the clocks in a line, the lines in a frame, the width of each sync pulse, the active area, the offset of the active area from each sync's leading edge, a polarity bit per sync, and an interlace flag. A horizontal counter and a vertical counter both start at zero on the sync leading edge. The horizontal counter runs across a line and wraps. The vertical counter advances on each horizontal wrap. The outputs are decoded from these two counters.

The configuration inputs are copied into a shadow set when reset is active and again at each frame wrap. A change on the configuration bus in the middle of a frame therefore never produces a torn frame. An enable input freezes all timing state while it is low. In interlaced mode a field output flips at each frame wrap.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is low, x and y are 0, field is 0, and the configuration inputs are captured. With en low, sof and eol are 0.
- R2: With en high, x counts 0 to line_total-1 and then wraps to 0. On each wrap of x, y advances by 1. On the wrap of x that occurs at y = frame_total-1, y returns to 0.
- R3: The internal hsync is active while x < hsync_len. The internal vsync is active while y < vsync_len.
- R4: polarity bit 0 controls hsync and polarity bit 1 controls vsync. A bit value of 1 drives the sync active-high. A bit value of 0 drives the inverted level.
- R5: de is 1 exactly when h_offset ≤ x < h_offset+act_w and v_offset ≤ y < v_offset+act_h.
- R6: sof is 1 when en is high and x = 0 and y = 0. Otherwise sof is 0.
- R7: eol is 1 when en is high and x = line_total-1. Otherwise eol is 0.
- R8: While en is low, x, y and field hold their values.
- R9: Configuration values presented during a frame take effect only from the first cycle of the next frame. This includes values changed on the last cycle of a frame.
- R10: At each frame wrap, field toggles if the interlace flag of the frame that is ending was 1. If that flag was 0, field is set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance timing when high |
| line_total | input | 16 | Clocks per line |
| frame_total | input | 16 | Lines per frame |
| hsync_len | input | 15 | Horizontal sync width in clocks |
| vsync_len | input | 15 | Vertical sync width in lines |
| act_w | input | 16 | Active pixels per line |
| act_h | input | 16 | Active lines per frame |
| h_offset | input | 16 | Clocks from hsync leading edge to first active pixel |
| v_offset | input | 16 | Lines from vsync leading edge to first active line |
| polarity | input | 2 | Bit 0 sets hsync polarity, bit 1 sets vsync polarity |
| ilace | input | 1 | 1 marks the source as interlaced |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-video enable |
| sof | output | 1 | Start-of-frame pulse |
| eol | output | 1 | End-of-line pulse |
| x | output | 16 | Current clock within line |
| y | output | 16 | Current line within frame |
| field | output | 1 | Field toggle for interlaced sources |

## Verification
Two events can fall on the same edge: the frame wrap and a configuration change. The bench provokes this by driving a new geometry, new polarities and the interlace flag on the final cycle of a frame, where x = line_total-1 and y = frame_total-1. The remaining cycles of that frame must still match the old settings. Every output of the following frame must match the new settings. The field bit must stay 0 across that wrap, because it follows the flag of the frame that is ending, and then flip on the wrap after. A second change, made in the middle of a frame, confirms that the remaining cycles of that frame keep the old settings.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CW = 16,
  parameter int SW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] line_total,
  input  logic [CW-1:0] frame_total,
  input  logic [SW-1:0] hsync_len,
  input  logic [SW-1:0] vsync_len,
  input  logic [CW-1:0] act_w,
  input  logic [CW-1:0] act_h,
  input  logic [CW-1:0] h_offset,
  input  logic [CW-1:0] v_offset,
  input  logic [1:0]    polarity,
  input  logic          ilace,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          sof,
  output logic          eol,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic          field
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam int PAD = CW - SW;

  logic [CW-1:0] s_lt, s_ft, s_aw, s_ah, s_ho, s_vo;
  logic [SW-1:0] s_hw, s_vw;
  logic [1:0]    s_pol;
  logic          s_il;

  logic last_x, last_y, wrap;
  assign last_x = (x == s_lt - ONE);
  assign last_y = (y == s_ft - ONE);
  assign wrap   = en && last_x && last_y;

  always_ff @(posedge clk) begin
    if (!rst_n || wrap) begin
      s_lt  <= line_total;
      s_ft  <= frame_total;
      s_hw  <= hsync_len;
      s_vw  <= vsync_len;
      s_aw  <= act_w;
      s_ah  <= act_h;
      s_ho  <= h_offset;
      s_vo  <= v_offset;
      s_pol <= polarity;
      s_il  <= ilace;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x     <= '0;
      y     <= '0;
      field <= 1'b0;
    end else if (en) begin
      if (last_x) begin
        x <= '0;
        y <= last_y ? '0 : y + ONE;
        if (last_y) field <= s_il ? ~field : 1'b0;
      end else begin
        x <= x + ONE;
      end
    end
  end

  logic hs_on, vs_on;
  assign hs_on = x < {{PAD{1'b0}}, s_hw};
  assign vs_on = y < {{PAD{1'b0}}, s_vw};
  assign hsync = s_pol[0] ? hs_on : ~hs_on;
  assign vsync = s_pol[1] ? vs_on : ~vs_on;

  logic [CW:0] h_end, v_end;
  assign h_end = {1'b0, s_ho} + {1'b0, s_aw};
  assign v_end = {1'b0, s_vo} + {1'b0, s_ah};
  assign de = (x >= s_ho) && ({1'b0, x} < h_end) &&
              (y >= s_vo) && ({1'b0, y} < v_end);

  assign sof = en && (x == '0) && (y == '0);
  assign eol = en && last_x;

  p_x_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && last_x |=> x == '0);
  p_x_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && !last_x |=> x == $past(x) + ONE);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(x) && $stable(y) && $stable(field));
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(s_lt) && $stable(s_ft) && $stable(s_pol) && $stable(s_il));
  p_field_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && s_il |=> field != $past(field));
  p_sof_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sof && s_lt > ONE |=> !sof);
endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  localparam int CLK_P = 10;

  typedef struct {
    int lt, ft, hsw, vsw, ho, vo, aw, ah, pol, il;
  } cfg_t;

  logic clk = 0, rst_n = 0, en = 0;
  logic [15:0] line_total, frame_total, act_w, act_h, h_offset, v_offset;
  logic [14:0] hsync_len, vsync_len;
  logic [1:0]  polarity;
  logic        ilace;
  logic hsync, vsync, de, sof, eol, field;
  logic [15:0] x, y;

  int checks = 0, fails = 0;
  bit done = 0;
  cfg_t e_cfg, nxt_cfg, cfg_a, cfg_b, cfg_c;
  bit e_field = 0;

  always #(CLK_P/2) clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .en(en),
    .line_total(line_total), .frame_total(frame_total),
    .hsync_len(hsync_len), .vsync_len(vsync_len),
    .act_w(act_w), .act_h(act_h), .h_offset(h_offset), .v_offset(v_offset),
    .polarity(polarity), .ilace(ilace),
    .hsync(hsync), .vsync(vsync), .de(de), .sof(sof), .eol(eol),
    .x(x), .y(y), .field(field)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (x=%0d y=%0d)", tag, act, exp, x, y);
    end
  endtask

  task automatic drive(input cfg_t c);
    line_total  = 16'(c.lt);  frame_total = 16'(c.ft);
    hsync_len   = 15'(c.hsw); vsync_len   = 15'(c.vsw);
    h_offset    = 16'(c.ho);  v_offset    = 16'(c.vo);
    act_w       = 16'(c.aw);  act_h       = 16'(c.ah);
    polarity    = 2'(c.pol);  ilace       = c.il[0];
  endtask

  // One full frame from the origin; optionally present nxt_cfg at cycle chg_at.
  task automatic sweep(input string name, input int chg_at);
    bit changed = 0;
    for (int n = 0; n < e_cfg.lt * e_cfg.ft; n++) begin
      int ex = n % e_cfg.lt;
      int ey = n / e_cfg.lt;
      bit hs = ex < e_cfg.hsw;
      bit vs = ey < e_cfg.vsw;
      chk({name, " R2 x"}, int'(x), ex);
      chk({name, " R2 y"}, int'(y), ey);
      chk({name, " R3/R4 hsync"}, int'(hsync), e_cfg.pol[0] ? int'(hs) : int'(!hs));
      chk({name, " R3/R4 vsync"}, int'(vsync), e_cfg.pol[1] ? int'(vs) : int'(!vs));
      chk({name, " R5 de"}, int'(de),
          int'(ex >= e_cfg.ho && ex < e_cfg.ho + e_cfg.aw &&
               ey >= e_cfg.vo && ey < e_cfg.vo + e_cfg.ah));
      chk({name, " R6 sof"}, int'(sof), int'(ex == 0 && ey == 0));
      chk({name, " R7 eol"}, int'(eol), int'(ex == e_cfg.lt - 1));
      chk({name, " R10 field"}, int'(field), int'(e_field));
      if (n == chg_at) begin
        drive(nxt_cfg);
        changed = 1;
      end
      @(posedge clk); @(negedge clk);
    end
    e_field = e_cfg.il != 0 ? ~e_field : 1'b0;
    if (changed) e_cfg = nxt_cfg;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 x", int'(x), 0);
    chk("R1 y", int'(y), 0);
    chk("R1 field", int'(field), 0);
    chk("R1 sof", int'(sof), 0);
    chk("R1 eol", int'(eol), 0);
    chk("R1 hsync", int'(hsync), 1);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 x held", int'(x), 0);
      chk("R8 y held", int'(y), 0);
      chk("R6 sof gated", int'(sof), 0);
    end
    en = 1;
    #1;
    chk("R6 sof enabled", int'(sof), 1);
  endtask

  task automatic t_mid_change();
    nxt_cfg = cfg_b;
    sweep("R9 mid-frame", 17);
    sweep("R9 new geometry", -1);
  endtask

  task automatic t_boundary_change();
    nxt_cfg = cfg_c;
    sweep("R9 last-cycle", cfg_b.lt * cfg_b.ft - 1);
  endtask

  task automatic t_interlace();
    sweep("R10 field0", -1);
    sweep("R10 field1", -1);
    chk("R10 field back", int'(field), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cfg_a = '{lt:10, ft:6, hsw:2, vsw:1, ho:3, vo:2, aw:4, ah:3, pol:3, il:0};
    cfg_b = '{lt:12, ft:5, hsw:3, vsw:2, ho:4, vo:1, aw:5, ah:2, pol:0, il:0};
    cfg_c = cfg_a;
    cfg_c.pol = 1;
    cfg_c.il = 1;
    drive(cfg_a);
    e_cfg = cfg_a;
    repeat (4) @(posedge clk);
    t_reset();
    rst_n = 1;
    t_hold();
    sweep("frame A", -1);
    t_mid_change();
    t_boundary_change();
    t_interlace();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    done = 1;
    $finish;
  end
endmodule